// File: doc/BRIEF.md
# Supply-Steered Resolution Calibration Loop

This block runs in the background of a fractional-N digital PLL. It holds the step size of a delay-line time quantizer at its target value. It does this by steering the quantizer's supply through a switched-capacitor boost converter. Once per reference cycle it takes the loop's phase error and the fractional part of the reference phase. It correlates the two into a least-mean-squares gradient, scales that gradient down by a power of two, and subtracts the result from a 12-bit tuning word.

The tuning word is compared against the middle of its range, which stands for the target resolution. The excess above the midpoint drives a first-order accumulator. Each carry out of that accumulator asks for one switching cycle of the boost converter to be skipped. Skipped cycles are therefore spread evenly across time, and their density is proportional to the excess. A word at or below the midpoint never skips, which lets the supply rise.

Updates happen only while the PLL reports lock and calibration is enabled, and only after both have been held for a settling window. The small step keeps the calibration loop far slower than the PLL loop.

Top module: `resCalLoop`

## Requirements
- R1: After a synchronous active-low reset, `ttwOut` is 2048 (the midpoint of the 12-bit range) and `skipOut` is 0.
- R2: An update is applied at a rising edge only when `lockIn` and `calEn` are both high at that edge and were both high at each of the previous SETTLE_CYC (default 4) edges. A cycle with either input low restarts this count.
- R3: The centered phase is `fracPhase - 128` (signed). The gradient is `phaseErr * centered phase`, and the step is that gradient shifted right arithmetically by 10 bits (rounding toward minus infinity). A step's magnitude never exceeds 256.
- R4: On an update, the new tuning word is the old word minus the step.
- R5: The tuning word saturates at 0 and at 4095 and never wraps.
- R6: When `lockIn` or `calEn` is low at an edge, the tuning word is unchanged at that edge.
- R7: One cycle after the tuning word is at or below 2048, `skipOut` is 0.
- R8: With the tuning word held constant above 2048, `skipOut` is high in exactly `ttwOut - 2048` of any 2048 consecutive cycles.
- R9: With the tuning word held constant at an excess of at most 1024 over the midpoint, `skipOut` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock; one calibration iteration per edge |
| rstN | input | 1 | Synchronous reset, active low |
| lockIn | input | 1 | PLL lock indication |
| calEn | input | 1 | Calibration enable |
| phaseErr | input | 12 | Signed phase error sample |
| fracPhase | input | 8 | Fractional reference phase, unsigned, 128 is the center |
| ttwOut | output | 12 | Current tuning word |
| skipOut | output | 1 | High to suppress the boost converter's switching for this cycle |

## Verification
The hardest condition to reach is a tuning word pinned at either end of its range, where saturation and skip density can be observed. A single update moves the word by at most 256. The bench therefore drives long runs of phase-error and fractional-phase pairs chosen so that every gradient has the same sign, then freezes the word by dropping the enable. With the word frozen, the bench counts skip pulses over a full accumulator period. A second frozen word is reached exactly by two maximal steps from the reset midpoint, and at that word the bench checks both the skip count and that no two skips are adjacent.

// File: rtl/resCalPkg.sv
package resCalPkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic upd;
  } calStrobeT;
endpackage

// File: rtl/resCalCtrl.sv
module resCalCtrl
  import resCalPkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lockIn,
  input  logic      calEn,
  output calStrobeT strobe
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(SETTLE_CYC);

  logic          armed;
  logic [CW-1:0] settleCnt;

  assign armed = lockIn && calEn;

  // counts consecutive armed edges, saturating at the window length
  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (!armed) begin
      settleCnt <= '0;
    end else if (settleCnt != CNT_TOP) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  always_comb begin
    strobe     = '0;
    strobe.upd = armed && (settleCnt == CNT_TOP);
  end
endmodule

// File: rtl/resCalGrad.sv
module resCalGrad #(
  parameter int PHE_W    = 12,
  parameter int FRAC_W   = 8,
  parameter int MU_SHIFT = 10
) (
  input  logic signed [PHE_W-1:0]    phaseErr,
  input  logic        [FRAC_W-1:0]   fracPhase,
  output logic signed [PHE_W+FRAC_W:0] stepVal
);
  localparam int PROD_W = PHE_W + FRAC_W + 1;
  localparam logic signed [FRAC_W:0] FRAC_MID = {2'b01, {(FRAC_W-1){1'b0}}};

  logic signed [FRAC_W:0]   fracCtr;
  logic signed [PROD_W-1:0] grad;

  always_comb begin
    fracCtr = $signed({1'b0, fracPhase}) - FRAC_MID;
    grad    = PROD_W'(phaseErr) * PROD_W'(fracCtr);
    stepVal = grad >>> MU_SHIFT;
  end
endmodule

// File: rtl/resCalSkip.sv
module resCalSkip #(
  parameter int TTW_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TTW_W-1:0] ttw,
  output logic             skipQ
);
  localparam int AW = TTW_W - 1;

  logic [AW-1:0] acc;
  logic [AW-1:0] excess;
  logic [AW:0]   sum;

  always_comb begin
    excess = ttw[TTW_W-1] ? ttw[AW-1:0] : '0;
    sum    = {1'b0, acc} + {1'b0, excess};
  end

  // first-order accumulator: the carry marks a skipped switching cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      skipQ <= 1'b0;
    end else begin
      acc   <= sum[AW-1:0];
      skipQ <= sum[AW];
    end
  end
endmodule

// File: rtl/resCalDatapath.sv
module resCalDatapath
  import resCalPkg::*;
#(
  parameter int PHE_W    = 12,
  parameter int FRAC_W   = 8,
  parameter int TTW_W    = 12,
  parameter int MU_SHIFT = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  calStrobeT               strobe,
  input  logic signed [PHE_W-1:0] phaseErr,
  input  logic [FRAC_W-1:0]       fracPhase,
  output logic [TTW_W-1:0]        ttwQ,
  output logic                    skipQ
);
  localparam int PROD_W = PHE_W + FRAC_W + 1;
  localparam int NW = ((PROD_W > TTW_W) ? PROD_W : TTW_W) + 2;
  localparam logic [TTW_W-1:0] TTW_MID = {1'b1, {(TTW_W-1){1'b0}}};
  localparam logic signed [NW-1:0] TTW_TOP = NW'((1 << TTW_W) - 1);

  logic signed [PROD_W-1:0] stepVal;
  logic signed [NW-1:0]     ttwExt;
  logic signed [NW-1:0]     stepExt;
  logic signed [NW-1:0]     cand;
  logic [TTW_W-1:0]         ttwNext;

  resCalGrad #(
    .PHE_W   (PHE_W),
    .FRAC_W  (FRAC_W),
    .MU_SHIFT(MU_SHIFT)
  ) u_grad (
    .phaseErr (phaseErr),
    .fracPhase(fracPhase),
    .stepVal  (stepVal)
  );

  // subtract the step and clamp to the tuning range
  always_comb begin
    ttwExt  = $signed(NW'({1'b0, ttwQ}));
    stepExt = NW'(stepVal);
    cand    = ttwExt - stepExt;
    if (cand < 0) begin
      ttwNext = '0;
    end else if (cand > TTW_TOP) begin
      ttwNext = '1;
    end else begin
      ttwNext = cand[TTW_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ttwQ <= TTW_MID;
    end else if (strobe.upd) begin
      ttwQ <= ttwNext;
    end
  end

  resCalSkip #(
    .TTW_W(TTW_W)
  ) u_skip (
    .clk  (clk),
    .rstN (rstN),
    .ttw  (ttwQ),
    .skipQ(skipQ)
  );
endmodule

// File: rtl/resCalLoop.sv
module resCalLoop
  import resCalPkg::*;
#(
  parameter int PHE_W      = 12,
  parameter int FRAC_W     = 8,
  parameter int TTW_W      = 12,
  parameter int MU_SHIFT   = 10,
  parameter int SETTLE_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lockIn,
  input  logic                    calEn,
  input  logic signed [PHE_W-1:0] phaseErr,
  input  logic [FRAC_W-1:0]       fracPhase,
  output logic [TTW_W-1:0]        ttwOut,
  output logic                    skipOut
);
  calStrobeT strobe;

  resCalCtrl #(
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .lockIn(lockIn),
    .calEn (calEn),
    .strobe(strobe)
  );

  resCalDatapath #(
    .PHE_W   (PHE_W),
    .FRAC_W  (FRAC_W),
    .TTW_W   (TTW_W),
    .MU_SHIFT(MU_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .phaseErr (phaseErr),
    .fracPhase(fracPhase),
    .ttwQ     (ttwOut),
    .skipQ    (skipOut)
  );
endmodule

// File: rtl/resCalChk.sv
module resCalChk #(
  parameter int PHE_W      = 12,
  parameter int FRAC_W     = 8,
  parameter int TTW_W      = 12,
  parameter int MU_SHIFT   = 10,
  parameter int SETTLE_CYC = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             lockIn,
  input logic             calEn,
  input logic [TTW_W-1:0] ttwOut,
  input logic             skipOut
);
  localparam int STEP_MAX = ((1 << (PHE_W - 1)) * (1 << (FRAC_W - 1))) >> MU_SHIFT;
  localparam logic [TTW_W-1:0] MID = {1'b1, {(TTW_W-1){1'b0}}};

  logic [15:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (!(lockIn && calEn)) begin
      runLen <= '0;
    end else if (runLen != 16'hFFFF) begin
      runLen <= runLen + 1'b1;
    end
  end

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lockIn && calEn) |=> $stable(ttwOut));

  // R2
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runLen < SETTLE_CYC) |=> $stable(ttwOut));

  // R7
  no_skip_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ttwOut <= MID) |=> !skipOut);

  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($signed({2'b00, ttwOut}) - $signed({2'b00, $past(ttwOut)})) <= STEP_MAX) &&
              (($signed({2'b00, ttwOut}) - $signed({2'b00, $past(ttwOut)})) >= -STEP_MAX)));
endmodule

bind resCalLoop resCalChk #(
  .PHE_W     (PHE_W),
  .FRAC_W    (FRAC_W),
  .TTW_W     (TTW_W),
  .MU_SHIFT  (MU_SHIFT),
  .SETTLE_CYC(SETTLE_CYC)
) u_resCalChk (
  .clk    (clk),
  .rstN   (rstN),
  .lockIn (lockIn),
  .calEn  (calEn),
  .ttwOut (ttwOut),
  .skipOut(skipOut)
);

// File: tb/test_resCalLoop.sv
module test_resCalLoop;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lockIn = 1'b0;
  logic              calEn = 1'b0;
  logic signed [11:0] phaseErr = '0;
  logic [7:0]        fracPhase = 8'd128;
  logic [11:0]       ttwOut;
  logic              skipOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  // stimulus rows: phase error, fractional phase, expected change of the tuning word
  localparam int PE_T [8] = '{1000, -1000, 2047, -2048, 1, -1, 0, 500};
  localparam int FR_T [8] = '{255, 255, 0, 0, 129, 129, 200, 64};
  localparam int DT_T [8] = '{-124, 125, 256, -256, 0, 1, 0, 32};

  always #4 clk = ~clk;

  resCalLoop i_resCalLoop (
    .clk      (clk),
    .rstN     (rstN),
    .lockIn   (lockIn),
    .calEn    (calEn),
    .phaseErr (phaseErr),
    .fracPhase(fracPhase),
    .ttwOut   (ttwOut),
    .skipOut  (skipOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int pe, input int fr, input bit lk, input bit en);
    phaseErr  = 12'(pe);
    fracPhase = 8'(fr);
    lockIn    = lk;
    calEn     = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic countSkips(input int n, output int cnt, output bit adj);
    bit prev = 1'b0;
    cnt = 0;
    adj = 1'b0;
    for (int i = 0; i < n; i++) begin
      step(0, 128, 1'b1, 1'b0);
      if (skipOut) cnt++;
      if (skipOut && prev) adj = 1'b1;
      prev = skipOut;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(0, 128, 1'b0, 1'b0);
    step(0, 128, 1'b0, 1'b0);
    rstN = 1'b1;
  endtask

  initial begin
    int expTtw;
    int cnt;
    bit adj;
    int skipSeen;
    @(negedge clk);
    doReset();
    chk(ttwOut == 12'd2048, "R1 reset word", ttwOut, 2048);
    chk(skipOut == 1'b0, "R1 reset skip", skipOut, 0);

    // R2: settling window holds the word for four armed edges
    for (int i = 0; i < 4; i++) begin
      step(PE_T[0], FR_T[0], 1'b1, 1'b1);
      chk(ttwOut == 12'd2048, "R2 settle hold", ttwOut, 2048);
    end

    // R3 R4: table walk, one update per row
    expTtw = 2048;
    for (int i = 0; i < 8; i++) begin
      step(PE_T[i], FR_T[i], 1'b1, 1'b1);
      expTtw = expTtw + DT_T[i];
      chk(int'(ttwOut) == expTtw, "R3 R4 table update", ttwOut, expTtw);
    end

    // R6: enable low, then lock low
    for (int i = 0; i < 3; i++) begin
      step(1000, 255, 1'b1, 1'b0);
      chk(int'(ttwOut) == expTtw, "R6 hold enable low", ttwOut, expTtw);
    end
    for (int i = 0; i < 2; i++) begin
      step(1000, 255, 1'b0, 1'b1);
      chk(int'(ttwOut) == expTtw, "R6 hold lock low", ttwOut, expTtw);
    end

    // R2: window restarts after a drop
    for (int i = 0; i < 4; i++) begin
      step(-1, 129, 1'b1, 1'b1);
      chk(int'(ttwOut) == expTtw, "R2 restart hold", ttwOut, expTtw);
    end
    step(-1, 129, 1'b1, 1'b1);
    expTtw = expTtw + 1;
    chk(int'(ttwOut) == expTtw, "R2 first update after restart", ttwOut, expTtw);

    // R5: drive to the top
    for (int i = 0; i < 20; i++) step(-2048, 255, 1'b1, 1'b1);
    chk(ttwOut == 12'd4095, "R5 saturate top", ttwOut, 4095);
    for (int i = 0; i < 3; i++) step(-2048, 255, 1'b1, 1'b1);
    chk(ttwOut == 12'd4095, "R5 stay at top", ttwOut, 4095);

    // R8: full-scale skip density
    step(0, 128, 1'b1, 1'b0);
    step(0, 128, 1'b1, 1'b0);
    countSkips(2048, cnt, adj);
    chk(cnt == 2047, "R8 skip count at top", cnt, 2047);

    // R1 again, then exact word 2560
    doReset();
    chk(ttwOut == 12'd2048, "R1 second reset word", ttwOut, 2048);
    chk(skipOut == 1'b0, "R1 second reset skip", skipOut, 0);
    skipSeen = 0;
    for (int i = 0; i < 4; i++) begin
      step(0, 128, 1'b1, 1'b1);
      if (skipOut) skipSeen++;
    end
    chk(skipSeen == 0, "R7 no skip at midpoint", skipSeen, 0);
    step(2047, 0, 1'b1, 1'b1);
    step(2047, 0, 1'b1, 1'b1);
    chk(ttwOut == 12'd2560, "R4 two maximal steps", ttwOut, 2560);

    // R8 R9: quarter density, evenly spread
    step(0, 128, 1'b1, 1'b0);
    step(0, 128, 1'b1, 1'b0);
    countSkips(2048, cnt, adj);
    chk(cnt == 512, "R8 skip count at 2560", cnt, 512);
    chk(adj == 1'b0, "R9 no adjacent skips", int'(adj), 0);

    // R5: drive to the bottom
    for (int i = 0; i < 4; i++) step(0, 128, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step(2047, 255, 1'b1, 1'b1);
    chk(ttwOut == 12'd0, "R5 saturate bottom", ttwOut, 0);
    step(2047, 255, 1'b1, 1'b1);
    step(2047, 255, 1'b1, 1'b1);
    chk(ttwOut == 12'd0, "R5 stay at bottom", ttwOut, 0);

    // R7: no skipping below the midpoint
    countSkips(100, cnt, adj);
    chk(cnt == 0, "R7 no skip below midpoint", cnt, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog all requirements actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule